// File: doc/BRIEF.md
# Millisecond Periodic Interrupt Timer

This block is a periodic interrupt source meant to sit beside a real-time clock. It has a 16-bit up-counter that advances on a one-cycle millisecond tick pulse, a 16-bit compare register, and three status bits: a run enable, an interrupt enable and a sticky match flag. When the counter equals the compare value on a tick, the flag is raised and the counter starts again from zero. Repeated matches therefore produce a periodic event.

Software reaches the block through a simple single-cycle register port. A write strobe with a 2-bit address and a write data word updates a register. The read data is a combinational function of the address. The flag is cleared by writing a one to its bit. The interrupt output is the flag gated by the interrupt enable. The millisecond tick is produced elsewhere and arrives as an input pulse.

Top module: `msec_pit`

## Requirements
- R1: After reset the status, compare and counter registers all read zero and `irq` is low.
- R2: While the run bit (status bit 15) is clear, ticks leave the counter unchanged.
- R3: While the run bit is set, each cycle with `tick` high raises the counter by one. A cycle without `tick` leaves the counter unchanged.
- R4: A match happens when, on a tick, run (bit 15) and interrupt enable (bit 14) are set, the flag (bit 13) is clear and the counter equals the compare value. On the next cycle the flag reads 1 and the counter reads 0.
- R5: A tick with the counter equal to the compare value but no match (interrupt enable clear, or flag already set) simply increments the counter. The counter wraps from 0xFFFF to 0x0000.
- R6: Writing the status register with bit 13 set clears the flag. Writing it with bit 13 clear leaves the flag as it was. If a match and a clearing write fall in the same cycle, the flag ends set.
- R7: A counter write loads `wdata[15:0]`. When it falls in the same cycle as a tick, the written value is kept and that tick is discarded, with no increment and no match.
- R8: `irq` is high exactly when the flag and the interrupt enable are both set.
- R9: The register map is: address 0 is status, address 1 is compare, address 2 is the counter, and address 3 reads zero. A status write loads run from `wdata[15]` and interrupt enable from `wdata[14]`. Status reads return run, interrupt enable and flag in bits 15, 14 and 13, with all other bits zero. Compare and counter reads return their 16 bits zero-extended. A compare write keeps only `wdata[15:0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle millisecond pulse |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The counter is driven with several tick patterns, and each one separates a different fault:
- Ticks with run clear separate a missing enable gate from a correct hold.
- Ticks with run set and interrupt enable clear show whether the match wrongly ignores the interrupt enable.
- Ticks across the compare value with the flag already set expose a restart that ignores the flag.
- A counter preloaded near 0xFFFF checks the wrap.
- Back-to-back periods with a small compare value show that each match restarts from zero.

Same-cycle collisions are also applied: a tick together with a counter write, and a match together with a flag-clearing write. These confirm the priority rules that a plain sequence of single actions cannot reach.

// File: rtl/pit_pkg.sv
package pit_pkg;
   typedef enum logic [1:0] {
      PIT_A_STAT = 2'd0,
      PIT_A_CMP  = 2'd1,
      PIT_A_CNT  = 2'd2,
      PIT_A_NONE = 2'd3
   } pit_addr_e;

   localparam int PIT_RUN_BIT  = 15;
   localparam int PIT_IEN_BIT  = 14;
   localparam int PIT_FLAG_BIT = 13;
   localparam int PIT_STAT_W   = PIT_RUN_BIT + 1;
endpackage

// File: rtl/pit_status.sv
module pit_status (
   input  logic clk,
   input  logic rst_n,
   input  logic wr,
   input  logic run_d,
   input  logic ien_d,
   input  logic clr_req,
   input  logic hit,
   output logic run,
   output logic ien,
   output logic flag
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run  <= 1'b0;
         ien  <= 1'b0;
         flag <= 1'b0;
      end else begin
         if (wr) begin
            run <= run_d;
            ien <= ien_d;
         end
         if (hit)
            flag <= 1'b1;
         else if (wr && clr_req)
            flag <= 1'b0;
      end
   end
endmodule

// File: rtl/pit_counter.sv
module pit_counter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         adv,
   input  logic         restart,
   output logic [W-1:0] cnt
);
   localparam logic [W-1:0] ONE = W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (adv)
         cnt <= restart ? '0 : cnt + ONE;
   end
endmodule

// File: rtl/pit_match.sv
module pit_match #(
   parameter int W = 16
) (
   input  logic         tick,
   input  logic         run,
   input  logic         ien,
   input  logic         flag,
   input  logic         load,
   input  logic [W-1:0] cnt,
   input  logic [W-1:0] cmp,
   output logic         adv,
   output logic         hit
);
   always_comb begin
      adv = tick && run && !load;
      hit = adv && ien && !flag && (cnt == cmp);
   end
endmodule

// File: rtl/pit_readmux.sv
module pit_readmux
   import pit_pkg::*;
#(
   parameter int W  = 16,
   parameter int DW = 32
) (
   input  logic [1:0]    addr,
   input  logic          run,
   input  logic          ien,
   input  logic          flag,
   input  logic [W-1:0]  cmp,
   input  logic [W-1:0]  cnt,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] stat_word, cmp_word, cnt_word;

   always_comb begin
      stat_word = '0;
      stat_word[PIT_RUN_BIT]  = run;
      stat_word[PIT_IEN_BIT]  = ien;
      stat_word[PIT_FLAG_BIT] = flag;
   end

   generate
      if (DW == W) begin : g_flat
         assign cmp_word = cmp;
         assign cnt_word = cnt;
      end else begin : g_pad
         assign cmp_word = {{(DW-W){1'b0}}, cmp};
         assign cnt_word = {{(DW-W){1'b0}}, cnt};
      end
   endgenerate

   always_comb begin
      unique case (pit_addr_e'(addr))
         PIT_A_STAT: rdata = stat_word;
         PIT_A_CMP:  rdata = cmp_word;
         PIT_A_CNT:  rdata = cnt_word;
         default:    rdata = '0;
      endcase
   end
endmodule

// File: rtl/msec_pit.sv
module msec_pit
   import pit_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_en,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              irq
);
   generate
      if (DATA_W < PIT_STAT_W) begin : g_bad_dw
         $error("msec_pit: DATA_W must hold the status bits");
      end
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cw
         $error("msec_pit: CNT_W must be in 2..DATA_W");
      end
   endgenerate

   logic             stat_wr, cmp_wr, cnt_wr;
   logic [CNT_W-1:0] wval;
   logic [CNT_W-1:0] cmp_q, cnt_q;
   logic             run, ien, flag, adv, hit;

   assign stat_wr = wr_en && (pit_addr_e'(addr) == PIT_A_STAT);
   assign cmp_wr  = wr_en && (pit_addr_e'(addr) == PIT_A_CMP);
   assign cnt_wr  = wr_en && (pit_addr_e'(addr) == PIT_A_CNT);
   assign wval    = wdata[CNT_W-1:0];

   generate
      if (DATA_W > CNT_W && DATA_W > PIT_STAT_W) begin : g_unused
         logic unused_wdata;
         assign unused_wdata = ^{wdata[DATA_W-1:CNT_W]};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         cmp_q <= '0;
      else if (cmp_wr)
         cmp_q <= wval;
   end

   pit_match #(.W(CNT_W)) u_match (
      .tick(tick), .run(run), .ien(ien), .flag(flag), .load(cnt_wr),
      .cnt(cnt_q), .cmp(cmp_q), .adv(adv), .hit(hit)
   );

   pit_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(cnt_wr), .load_val(wval),
      .adv(adv), .restart(hit), .cnt(cnt_q)
   );

   pit_status u_stat (
      .clk(clk), .rst_n(rst_n), .wr(stat_wr),
      .run_d(wdata[PIT_RUN_BIT]), .ien_d(wdata[PIT_IEN_BIT]),
      .clr_req(wdata[PIT_FLAG_BIT]), .hit(hit),
      .run(run), .ien(ien), .flag(flag)
   );

   pit_readmux #(.W(CNT_W), .DW(DATA_W)) u_rd (
      .addr(addr), .run(run), .ien(ien), .flag(flag),
      .cmp(cmp_q), .cnt(cnt_q), .rdata(rdata)
   );

   assign irq = flag && ien;
endmodule

// File: rtl/msec_pit_chk.sv
module msec_pit_chk #(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         tick,
   input logic         cnt_load,
   input logic [W-1:0] load_val,
   input logic         stat_wr,
   input logic         clr_req,
   input logic         run,
   input logic         ien,
   input logic         flag,
   input logic [W-1:0] cnt,
   input logic [W-1:0] cmp,
   input logic         irq
);
   // R2
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !cnt_load) |=> $stable(cnt));
   // R3 / R5
   a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && run && !cnt_load && !(ien && !flag && cnt == cmp))
      |=> cnt == $past(cnt) + W'(1));
   // R4
   a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && run && ien && !flag && cnt == cmp && !cnt_load)
      |=> (cnt == '0) && flag);
   // R4
   a_r4_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(tick && run && ien && cnt == cmp));
   // R6
   a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !(stat_wr && clr_req)) |=> flag);
   // R7
   a_r7_load: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_load |=> cnt == $past(load_val));
   // R8
   a_r8_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (flag && ien));
endmodule

bind msec_pit msec_pit_chk #(.W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_load(cnt_wr),
   .load_val(wval), .stat_wr(stat_wr), .clr_req(wdata[13]),
   .run(run), .ien(ien), .flag(flag), .cnt(cnt_q), .cmp(cmp_q),
   .irq(irq)
);

// File: tb/msec_pit_test.sv
module msec_pit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  addr = 2'd0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;

   int vecs = 0;
   int errs = 0;
   int m_cnt = 0, m_cmp = 0;
   bit m_run = 0, m_ien = 0, m_flag = 0;

   always #2 clk = ~clk;

   msec_pit uut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
   );

   function automatic logic [31:0] exp_rd(input logic [1:0] a);
      case (a)
         2'd0: return {16'd0, m_run, m_ien, m_flag, 13'd0};
         2'd1: return 32'(m_cmp);
         2'd2: return 32'(m_cnt);
         default: return 32'd0;
      endcase
   endfunction

   task automatic compare(input string tag);
      logic [31:0] e;
      e = exp_rd(addr);
      vecs++;
      if (rdata !== e) begin
         errs++;
         $display("FAIL %s rdata addr=%0d got=%h exp=%h", tag, addr, rdata, e);
      end
      vecs++;
      if (irq !== (m_flag && m_ien)) begin
         errs++;
         $display("FAIL %s irq got=%b exp=%b", tag, irq, m_flag && m_ien);
      end
   endtask

   // one clock: drive at negedge, model at posedge, compare at next negedge
   task automatic step(input bit t, input bit w, input logic [1:0] a,
                       input logic [31:0] d, input string tag);
      bit cnt_w, stat_w, hit;
      tick = t; wr_en = w; addr = a; wdata = d;
      @(posedge clk);
      if (rst_n) begin
         cnt_w  = w && a == 2'd2;
         stat_w = w && a == 2'd0;
         hit = t && m_run && m_ien && !m_flag && m_cnt == m_cmp && !cnt_w;
         if (cnt_w) m_cnt = d & 32'hFFFF;
         else if (t && m_run) m_cnt = hit ? 0 : (m_cnt + 1) & 32'hFFFF;
         if (w && a == 2'd1) m_cmp = d & 32'hFFFF;
         if (hit) m_flag = 1;
         else if (stat_w && d[13]) m_flag = 0;
         if (stat_w) begin m_run = d[15]; m_ien = d[14]; end
      end
      @(negedge clk);
      compare(tag);
   endtask

   task automatic peek(input logic [1:0] a, input string tag);
      tick = 0; wr_en = 0; addr = a;
      #1;
      compare(tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errs++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      peek(2'd0, "R1"); peek(2'd1, "R1"); peek(2'd2, "R1");
      // R2 run clear: ticks ignored
      for (int i = 0; i < 3; i++) step(1, 0, 2'd2, 0, "R2");
      // R9 status write: run only
      step(0, 1, 2'd0, 32'h0000_8000, "R9");
      // R3 counting, with gaps
      for (int i = 0; i < 4; i++) step(1, 0, 2'd2, 0, "R3");
      for (int i = 0; i < 2; i++) step(0, 0, 2'd2, 0, "R3");
      // R5 compare equal but interrupt enable clear: no restart
      step(0, 1, 2'd1, 32'h0000_0005, "R9");
      for (int i = 0; i < 2; i++) step(1, 0, 2'd2, 0, "R5");
      // R4 match with enables set
      step(0, 1, 2'd1, 32'h0000_0008, "R9");
      step(0, 1, 2'd0, 32'h0000_C000, "R9");
      for (int i = 0; i < 4; i++) step(1, 0, 2'd2, 0, "R4");
      peek(2'd0, "R4");
      // R5 flag set: pass compare and wrap
      step(0, 1, 2'd2, 32'h0000_0007, "R7");
      for (int i = 0; i < 3; i++) step(1, 0, 2'd2, 0, "R5");
      step(0, 1, 2'd2, 32'h0000_FFFE, "R7");
      for (int i = 0; i < 3; i++) step(1, 0, 2'd2, 0, "R5");
      // R6 writing zero to flag keeps it; R8 enable off hides irq
      step(0, 1, 2'd0, 32'h0000_C000, "R6");
      step(0, 1, 2'd0, 32'h0000_8000, "R8");
      step(0, 1, 2'd0, 32'h0000_C000, "R8");
      step(0, 1, 2'd0, 32'h0000_E000, "R6");
      // R4 periodic restart with small compare
      step(0, 1, 2'd1, 32'h0000_0002, "R9");
      step(0, 1, 2'd2, 32'h0000_0000, "R7");
      for (int i = 0; i < 3; i++) step(1, 0, 2'd2, 0, "R4");
      step(0, 1, 2'd0, 32'h0000_E000, "R6");
      for (int i = 0; i < 3; i++) step(1, 0, 2'd2, 0, "R4");
      peek(2'd0, "R4");
      // R6 match and clear in same cycle: set wins
      step(0, 1, 2'd0, 32'h0000_E000, "R6");
      step(0, 1, 2'd2, 32'h0000_0002, "R7");
      step(1, 1, 2'd0, 32'h0000_E000, "R6");
      peek(2'd2, "R6");
      // R7 counter write beats tick, upper bits dropped
      step(0, 1, 2'd0, 32'h0000_E000, "R6");
      step(1, 1, 2'd2, 32'h0001_0002, "R7");
      peek(2'd0, "R7");
      // R9 compare keeps low half, spare address reads zero
      step(0, 1, 2'd1, 32'hABCD_1234, "R9");
      peek(2'd3, "R9");
      step(0, 1, 2'd0, 32'hFFFF_FFFF, "R9");
      peek(2'd0, "R9");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end
endmodule